// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits between a memory controller's command scheduler and the column address pins of a synchronous DRAM. It holds a decoded copy of the mode word and reports the programmed access latency and the burst settings. For every read or write command it steps through the column addresses of the burst, one per clock, flagging the final beat. Lengths of 1, 2, 4, 8 and a whole 256-column row are supported. Columns follow either a wrapping linear order or an XOR order. An option cuts every write down to one beat while reads keep the programmed length.

A burst can be cut short by a stop pulse or replaced by a fresh command. The clock-enable input suspends the sequencer. When it is sampled low at one edge, everything presented at the following edge is disregarded and all outputs keep their values. Data transfer and the DQ bus are handled elsewhere.

Top module: `burst_col_seq`

## Requirements
- R1: Mode word bits [2:0] set the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives 256 beats (linear order only).
- R2: With mode bit 3 at 0 (linear order), beat i of a length-BL burst from column S is S with its low log2(BL) bits replaced by (S + i) mod BL.
- R3: With mode bit 3 at 1 (XOR order), beat i of a burst from column S is S XOR i.
- R4: Mode bits [6:4] set the access latency: codes 1, 2 and 3 give 1, 2 and 3, and `cas_lat` carries that value as a 2-bit number.
- R5: With mode bit 9 at 1, a write command produces a single beat, while a read uses the programmed length.
- R6: A mode load is rejected when the length code is 4, 5 or 6, when it is 7 with bit 3 set, when the latency code is 0 or 4 to 7, or when bit 7 or bit 8 is set. A rejected load sets `mode_err` and keeps every earlier setting. An accepted load clears `mode_err`.
- R7: A stop pulse ends the burst, so `col_vld` is low on the cycle after the edge that takes it. When a start pulse and a stop pulse come together, the start wins.
- R8: A start pulse during a burst abandons it, and beat 0 of the new burst appears on the next cycle.
- R9: When `cke` is sampled low at one edge, the next edge ignores all command and mode inputs, and `col`, `col_vld`, `last_beat` and `cas_lat` keep their values through it.
- R10: After reset there is no burst (`col_vld` and `last_beat` low), `mode_err` is low, and the settings are length 1, linear order, latency 2 and single-write off.
- R11: Beat 0 appears on the cycle after the start edge. `col_vld` stays high for exactly the burst length, and `last_beat` is high only on the final beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock enable; low suspends the following cycle |
| mode_ld | input | 1 | Load strobe for `mode_word` |
| mode_word | input | 10 | Mode word: length [2:0], order [3], latency [6:4], single-write [9] |
| cmd_start | input | 1 | Start a burst |
| cmd_col | input | COL_W | Starting column of the burst |
| cmd_wr | input | 1 | 1 for a write command, 0 for a read |
| cmd_stop | input | 1 | End the running burst |
| col | output | COL_W | Current column address |
| col_vld | output | 1 | `col` holds a burst beat |
| last_beat | output | 1 | Current beat is the final one |
| cas_lat | output | 2 | Decoded access latency (1 to 3) |
| mode_err | output | 1 | Last mode load was rejected |

## Verification
The suspension cycle is the hardest case to reach. It only appears when `cke` drops for exactly one window in the middle of a burst, or while a start pulse is waiting. The bench lowers `cke` between two falling edges while a length-8 burst is running and expects one beat to repeat. It then lowers `cke` again and offers a start pulse in the suspended window, and expects no burst to begin. The wrap orders are swept over every starting column at every length in both orders.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int MODE_W = 10;

  typedef struct packed {
    logic [2:0] len_code;
    logic       xor_ord;
    logic [1:0] lat;
    logic       wr_single;
  } mode_t;

  localparam mode_t MODE_RST = '{len_code: 3'd0, xor_ord: 1'b0, lat: 2'd2, wr_single: 1'b0};
endpackage

// File: rtl/bcg_mode_dec.sv
module bcg_mode_dec
  import bcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ld,
  input  logic [MODE_W-1:0] word,
  output mode_t             mode,
  output logic              err
);
  mode_t mode_q, mode_n;
  logic  err_q, err_n;
  logic  len_ok, lat_ok, pad_ok, bad;

  always_comb begin
    len_ok = (word[2:0] <= 3'd3) || ((word[2:0] == 3'd7) && !word[3]);
    lat_ok = (word[6:4] >= 3'd1) && (word[6:4] <= 3'd3);
    pad_ok = (word[8:7] == 2'b00);
    bad    = !(len_ok && lat_ok && pad_ok);
  end

  always_comb begin
    mode_n = mode_q;
    err_n  = err_q;
    if (en && ld) begin
      if (bad) begin
        err_n = 1'b1;
      end else begin
        mode_n.len_code  = word[2:0];
        mode_n.xor_ord   = word[3];
        mode_n.lat       = word[5:4];
        mode_n.wr_single = word[9];
        err_n            = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      err_q  <= err_n;
    end
  end

  assign mode = mode_q;
  assign err  = err_q;

  AST_BAD_LOAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ld && bad) |=> (err_q && $stable(mode_q))); // R6
  AST_LAT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ld && !bad) |=> (mode_q.lat != 2'd0) && !err_q); // R4
endmodule

// File: rtl/bcg_addr_gen.sv
module bcg_addr_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_wr,
  input  logic             stop,
  input  mode_t            mode,
  output logic [COL_W-1:0] col,
  output logic             col_vld,
  output logic             last_beat
);
  localparam logic [COL_W-1:0] FULL_M1 = {COL_W{1'b1}};

  logic             act_q, act_n;
  logic             xor_q, xor_n;
  logic [COL_W-1:0] base_q, base_n;
  logic [COL_W-1:0] idx_q, idx_n;
  logic [COL_W-1:0] lm1_q, lm1_n;
  logic [COL_W-1:0] bl_m1;
  logic             at_end;

  always_comb begin
    case (mode.len_code)
      3'd0:    bl_m1 = '0;
      3'd1:    bl_m1 = COL_W'(1);
      3'd2:    bl_m1 = COL_W'(3);
      3'd3:    bl_m1 = COL_W'(7);
      default: bl_m1 = FULL_M1;
    endcase
  end

  assign at_end = (idx_q == lm1_q);

  always_comb begin
    act_n  = act_q;
    xor_n  = xor_q;
    base_n = base_q;
    idx_n  = idx_q;
    lm1_n  = lm1_q;
    if (en) begin
      if (start) begin
        act_n  = 1'b1;
        xor_n  = mode.xor_ord;
        base_n = start_col;
        idx_n  = '0;
        lm1_n  = (start_wr && mode.wr_single) ? '0 : bl_m1;
      end else if (stop) begin
        act_n = 1'b0;
      end else if (act_q) begin
        if (at_end) act_n = 1'b0;
        else        idx_n = idx_q + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      xor_q  <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      lm1_q  <= '0;
    end else begin
      act_q  <= act_n;
      xor_q  <= xor_n;
      base_q <= base_n;
      idx_q  <= idx_n;
      lm1_q  <= lm1_n;
    end
  end

  always_comb begin
    if (xor_q) col = base_q ^ idx_q;
    else       col = (base_q & ~lm1_q) | ((base_q + idx_q) & lm1_q);
  end

  assign col_vld   = act_q;
  assign last_beat = act_q && at_end;

  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> col_vld); // R11
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stop && !start) |=> !col_vld); // R7
  AST_START_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start) |=> (col_vld && col == $past(start_col))); // R8
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start && start_wr && mode.wr_single) |=> last_beat); // R5
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              mode_ld,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              cmd_start,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              cmd_wr,
  input  logic              cmd_stop,
  output logic [COL_W-1:0]  col,
  output logic              col_vld,
  output logic              last_beat,
  output logic [1:0]        cas_lat,
  output logic              mode_err
);
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  logic       cke_q;
  mode_t      mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) cke_q <= 1'b1;
    else          cke_q <= cke;
  end

  bcg_mode_dec u_mode (
    .clk  (clk),
    .rst_n(rst_s_n),
    .en   (cke_q),
    .ld   (mode_ld),
    .word (mode_word),
    .mode (mode),
    .err  (mode_err)
  );

  bcg_addr_gen #(.COL_W(COL_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .en       (cke_q),
    .start    (cmd_start),
    .start_col(cmd_col),
    .start_wr (cmd_wr),
    .stop     (cmd_stop),
    .mode     (mode),
    .col      (col),
    .col_vld  (col_vld),
    .last_beat(last_beat)
  );

  assign cas_lat = mode.lat;

  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cke_q |=> ($stable(col) && $stable(col_vld) && $stable(last_beat) && $stable(cas_lat))); // R9
endmodule

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n, cke, mode_ld, cmd_start, cmd_wr, cmd_stop;
  logic [9:0]       mode_word;
  logic [COL_W-1:0] cmd_col, col;
  logic             col_vld, last_beat, mode_err;
  logic [1:0]       cas_lat;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .mode_ld(mode_ld), .mode_word(mode_word),
    .cmd_start(cmd_start), .cmd_col(cmd_col), .cmd_wr(cmd_wr), .cmd_stop(cmd_stop),
    .col(col), .col_vld(col_vld), .last_beat(last_beat), .cas_lat(cas_lat), .mode_err(mode_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] mk(input int len, input int xo, input int lat, input int sw);
    logic [9:0] w;
    w = '0;
    w[2:0] = 3'(len);
    w[3]   = 1'(xo);
    w[6:4] = 3'(lat);
    w[9]   = 1'(sw);
    return w;
  endfunction

  function automatic int exp_col(input int base, input int i, input int bl, input bit xo);
    if (xo) return base ^ i;
    return base - (base % bl) + ((base % bl) + i) % bl;
  endfunction

  task automatic set_mode(input logic [9:0] w, input bit exp_err, input int exp_lat, input string req);
    @(negedge clk); mode_ld = 1'b1; mode_word = w;
    @(negedge clk); mode_ld = 1'b0;
    chk(mode_err == exp_err && cas_lat == exp_lat, req, {mode_err, cas_lat}, {exp_err, 2'(exp_lat)});
  endtask

  task automatic run_burst(input int base, input bit wr, input int bl, input bit xo, input string req);
    @(negedge clk); cmd_start = 1'b1; cmd_col = COL_W'(base); cmd_wr = wr;
    @(negedge clk); cmd_start = 1'b0;
    for (int i = 0; i < bl; i++) begin
      int e;
      e = exp_col(base, i, bl, xo);
      chk(col_vld && col == e && last_beat == (i == bl - 1), req,
          {col_vld, last_beat, col}, {1'b1, (i == bl - 1), 8'(e)});
      @(negedge clk);
    end
    chk(!col_vld && !last_beat, req, {col_vld, last_beat}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; mode_ld = 1'b0; mode_word = '0;
    cmd_start = 1'b0; cmd_col = '0; cmd_wr = 1'b0; cmd_stop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!col_vld && !last_beat && !mode_err && cas_lat == 2, "R10",
        {col_vld, last_beat, mode_err, cas_lat}, 2);
    run_burst(8'h37, 1'b0, 1, 1'b0, "R10");

    // R4 latency decode
    set_mode(mk(0, 0, 1, 0), 1'b0, 1, "R4");
    set_mode(mk(0, 0, 3, 0), 1'b0, 3, "R4");
    set_mode(mk(0, 0, 2, 0), 1'b0, 2, "R4");

    // R1 / R2 / R3 / R11 sweep over lengths, orders and every start column
    for (int lc = 0; lc < 4; lc++) begin
      for (int xo = 0; xo < 2; xo++) begin
        set_mode(mk(lc, xo, 2, 0), 1'b0, 2, "R1");
        for (int s = 0; s < 256; s++)
          run_burst(s, 1'b0, 1 << lc, 1'(xo), xo ? "R3/R1/R11" : "R2/R1/R11");
      end
    end

    // R1 full row, linear, wraps past the top column
    set_mode(mk(7, 0, 3, 0), 1'b0, 3, "R1");
    run_burst(8'hFD, 1'b0, 256, 1'b0, "R1");
    run_burst(8'h00, 1'b1, 256, 1'b0, "R1");

    // R5 single-write option
    set_mode(mk(2, 0, 2, 1), 1'b0, 2, "R5");
    run_burst(8'h46, 1'b1, 1, 1'b0, "R5");
    run_burst(8'h46, 1'b0, 4, 1'b0, "R5");
    set_mode(mk(2, 1, 2, 0), 1'b0, 2, "R5");
    run_burst(8'h46, 1'b1, 4, 1'b1, "R5");

    // R6 rejected loads keep settings (length 4, XOR, latency 2)
    set_mode(mk(5, 0, 3, 0), 1'b1, 2, "R6");
    set_mode(mk(7, 1, 3, 0), 1'b1, 2, "R6");
    set_mode(mk(3, 0, 0, 0), 1'b1, 2, "R6");
    set_mode(mk(3, 0, 6, 0), 1'b1, 2, "R6");
    set_mode(mk(3, 0, 3, 0) | 10'h080, 1'b1, 2, "R6");
    set_mode(mk(3, 0, 3, 0) | 10'h100, 1'b1, 2, "R6");
    run_burst(8'h46, 1'b0, 4, 1'b1, "R6");
    set_mode(mk(3, 0, 3, 0), 1'b0, 3, "R6");
    run_burst(8'h46, 1'b0, 8, 1'b0, "R6");

    // R7 stop mid-burst
    @(negedge clk); cmd_start = 1'b1; cmd_col = 8'h20; cmd_wr = 1'b0;
    @(negedge clk); cmd_start = 1'b0;
    chk(col_vld && col == 8'h20, "R7", col, 8'h20);
    @(negedge clk);
    chk(col_vld && col == 8'h21, "R7", col, 8'h21);
    @(negedge clk);
    chk(col_vld && col == 8'h22, "R7", col, 8'h22);
    cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0;
    chk(!col_vld && !last_beat, "R7", col_vld, 0);
    // R7 start wins over stop
    @(negedge clk); cmd_start = 1'b1; cmd_stop = 1'b1; cmd_col = 8'h40;
    @(negedge clk); cmd_start = 1'b0; cmd_stop = 1'b0;
    chk(col_vld && col == 8'h40, "R7", {col_vld, col}, {1'b1, 8'h40});
    cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0;
    chk(!col_vld, "R7", col_vld, 0);

    // R8 restart mid-burst
    @(negedge clk); cmd_start = 1'b1; cmd_col = 8'h30;
    @(negedge clk); cmd_start = 1'b0;
    chk(col_vld && col == 8'h30, "R8", col, 8'h30);
    @(negedge clk);
    chk(col_vld && col == 8'h31, "R8", col, 8'h31);
    cmd_start = 1'b1; cmd_col = 8'h55;
    @(negedge clk); cmd_start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      int e;
      e = exp_col(8'h55, i, 8, 1'b0);
      chk(col_vld && col == e && last_beat == (i == 7), "R8", {last_beat, col}, {(i == 7), 8'(e)});
      @(negedge clk);
    end
    chk(!col_vld, "R8", col_vld, 0);

    // R9 suspension mid-burst repeats one beat
    @(negedge clk); cmd_start = 1'b1; cmd_col = 8'h10;
    @(negedge clk); cmd_start = 1'b0;
    for (int k = 0; k < 9; k++) begin
      int bi, e;
      bi = (k <= 3) ? k : k - 1;
      e  = 8'h10 + bi;
      chk(col_vld && col == e && last_beat == (bi == 7), "R9", {last_beat, col}, {(bi == 7), 8'(e)});
      if (k == 2) cke = 1'b0;
      if (k == 3) cke = 1'b1;
      @(negedge clk);
    end
    chk(!col_vld, "R9", col_vld, 0);
    // R9 start and mode load during a suspended cycle are ignored
    cke = 1'b0;
    @(negedge clk); cke = 1'b1; cmd_start = 1'b1; cmd_col = 8'h77; mode_ld = 1'b1; mode_word = mk(0, 0, 1, 0);
    @(negedge clk); cmd_start = 1'b0; mode_ld = 1'b0;
    chk(!col_vld && cas_lat == 3, "R9", {col_vld, cas_lat}, 3);
    @(negedge clk);
    chk(!col_vld && cas_lat == 3, "R9", {col_vld, cas_lat}, 3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule